// File: doc/BRIEF.md
# Cubic Spline Interpolator with Rate Shift

This block produces one signed 16-bit DAC sample per clock from a cubic polynomial segment. Four coefficients are held as a forward-difference set (position, slope, curvature, jerk). Each evolution step adds every difference into the order below it, so a cubic curve comes out using only adders. A segment is loaded in one cycle from a line of up to nine 16-bit words. Any words beyond the stated line length count as zero, so a short line gives a lower-order curve.

A per-segment rate exponent stretches each evolution step across 2^shift clock cycles. This allows long, slow ramps without losing coefficient resolution. A hold input freezes the curve, for example while the next segment is being fetched or while a trigger is pending. Nothing saturates: every accumulator wraps modulo its width.

Top module: `spline_cubic_shift`

## Requirements
- R1: After reset, and until the first load, `sample_o` is 0x0000.
- R2: In the cycle after a rising edge with `load_i` high, `sample_o` equals word 0 of the line, or 0 when the length is 0. This holds whatever `hold_i` is.
- R3: Words are packed least significant word first. Word i occupies `words_i[16*i+15:16*i]`. The slope is {w2,w1} (32 bits, 16.16). The curvature is {w5,w4,w3} (48 bits, 16.32). The jerk is {w8,w7,w6} (48 bits, 16.32). The order-0 accumulator is 32 bits (16.16) and loads {w0, 16'h0000}.
- R4: A word with index greater than or equal to `len_i` is replaced by zero at load.
- R5: One step updates all orders at once from their values before the step. Order 0 adds the slope. The slope adds the upper 32 bits of the curvature. The curvature adds the jerk. `sample_o` is the upper 16 bits of the order-0 accumulator.
- R6: With a rate exponent s, a step happens on every 2^s-th rising edge that has `hold_i` low. That count restarts at the load, so the first step lands on the 2^s-th such edge after the load edge. `sample_o` does not change on any other edge without a load.
- R7: A rising edge with `hold_i` high and `load_i` low leaves the accumulators and the step counter unchanged.
- R8: Every addition wraps modulo the accumulator width, with no clipping. For example, 0x7FFF plus one output step gives 0x8000.
- R9: A load replaces all four accumulators and restarts the step counter, even in the middle of a step interval or while held.
- R10: The rate exponent is taken from `shift_i` only on a load edge. Changes to `shift_i` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load strobe for a new segment |
| len_i | input | 4 | Number of valid words in the line (0 to 9) |
| words_i | input | 144 | Nine 16-bit coefficient words, word 0 in the low bits |
| shift_i | input | 4 | Rate exponent, captured at load |
| hold_i | input | 1 | Freeze evolution |
| sample_o | output | 16 | Two's complement output sample |

## Verification
The bound checker checks four things on every cycle. The output is zero out of reset. A load presents word 0, or zero for an empty line. The output stays still on any edge without a step. A held edge changes nothing. The exact sums of a step can only be shown by the bench's scenarios: word ordering and zero padding, wrap across full scale, spacing of steps under different rate exponents, and the point at which the exponent is captured. The bench compares these against its own cycle model of the requirements.

// File: rtl/spline_pkg.sv
`timescale 1ns/1ps
// Shared widths and the decoded coefficient record for the cubic spline block.
// Assumes 16-bit line words and a nine-word maximum line.
package spline_pkg;
    localparam int WORD_W   = 16;
    localparam int N_WORDS  = 9;
    localparam int LEN_W    = $clog2(N_WORDS + 1);
    localparam int SAMPLE_W = 16;
    localparam int ACC0_W   = 32;
    localparam int ACC1_W   = 32;
    localparam int ACC2_W   = 48;
    localparam int ACC3_W   = 48;
    localparam int LINE_W   = N_WORDS * WORD_W;

    typedef struct packed {
        logic [ACC3_W-1:0] jerk;
        logic [ACC2_W-1:0] curv;
        logic [ACC1_W-1:0] slope;
        logic [WORD_W-1:0] pos;
    } coef_t;
endpackage

// File: rtl/coef_unpack.sv
`timescale 1ns/1ps
// Zero-pads a coefficient line past its length and splits it into the four
// difference terms, least significant word first. Purely combinational.
module coef_unpack
    import spline_pkg::*;
(
    input  logic [LINE_W-1:0] words_i,
    input  logic [LEN_W-1:0]  len_i,
    output coef_t             coef_o
);
    localparam int SLOPE_LO = WORD_W;
    localparam int CURV_LO  = SLOPE_LO + ACC1_W;
    localparam int JERK_LO  = CURV_LO + ACC2_W;

    logic [LINE_W-1:0] padded;

    // Replace each word at or beyond the line length with zero.
    for (genvar i = 0; i < N_WORDS; i++) begin : g_pad
        assign padded[i*WORD_W +: WORD_W] =
            (LEN_W'(i) < len_i) ? words_i[i*WORD_W +: WORD_W] : '0;
    end

    // Slice the padded line into the difference terms.
    always_comb begin
        coef_o.pos   = padded[0 +: WORD_W];
        coef_o.slope = padded[SLOPE_LO +: ACC1_W];
        coef_o.curv  = padded[CURV_LO +: ACC2_W];
        coef_o.jerk  = padded[JERK_LO +: ACC3_W];
    end
endmodule

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
// Issues one step pulse every 2^shift un-held cycles. The exponent is
// captured at load, and a load restarts the count. Assumes load wins over hold.
module rate_divider #(
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               hold_i,
    output logic               step_o
);
    localparam int CNT_W = (1 << SHIFT_W) - 1;

    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   limit;

    // Terminal count for the captured exponent: 2^shift - 1.
    assign limit  = ~({CNT_W{1'b1}} << shift_q);
    assign step_o = !load_i && !hold_i && (cnt_q == limit);

    // Capture the exponent on load and count un-held cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            shift_q <= shift_i;
            cnt_q   <= '0;
        end else if (!hold_i) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/diff_engine.sv
`timescale 1ns/1ps
// Forward-difference accumulator chain. A load replaces every order. A step
// adds each order into the one below, using values from before the step.
// Every sum wraps.
module diff_engine
    import spline_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  coef_t               coef_i,
    input  logic                step_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam int FRAC0 = ACC0_W - SAMPLE_W;

    logic [ACC0_W-1:0] q0;
    logic [ACC1_W-1:0] q1;
    logic [ACC2_W-1:0] q2;
    logic [ACC3_W-1:0] q3;

    // Load the segment or advance it by one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0 <= '0;
            q1 <= '0;
            q2 <= '0;
            q3 <= '0;
        end else if (load_i) begin
            q0 <= {coef_i.pos, {FRAC0{1'b0}}};
            q1 <= coef_i.slope;
            q2 <= coef_i.curv;
            q3 <= coef_i.jerk;
        end else if (step_i) begin
            q0 <= q0 + q1;
            q1 <= q1 + q2[ACC2_W-1 -: ACC1_W];
            q2 <= q2 + q3;
        end
    end

    // The output is the integer part of the order-0 accumulator.
    assign sample_o = q0[ACC0_W-1 -: SAMPLE_W];
endmodule

// File: rtl/spline_cubic_shift.sv
`timescale 1ns/1ps
// Cubic spline interpolator. It unpacks a line, paces steps by 2^shift and
// drives one sample per clock. Assumes the upstream fetch asserts hold while
// the next line is not ready.
module spline_cubic_shift
    import spline_pkg::*;
#(
    parameter int SHIFT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [LINE_W-1:0]   words_i,
    input  logic [SHIFT_W-1:0]  shift_i,
    input  logic                hold_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    coef_t coef;
    logic  step;

    coef_unpack u_unpack (
        .words_i (words_i),
        .len_i   (len_i),
        .coef_o  (coef)
    );

    rate_divider #(.SHIFT_W(SHIFT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (shift_i),
        .hold_i  (hold_i),
        .step_o  (step)
    );

    diff_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .coef_i   (coef),
        .step_i   (step),
        .sample_o (sample_o)
    );
endmodule

// File: rtl/spline_cubic_shift_chk.sv
`timescale 1ns/1ps
// Cycle checker for the spline top. It watches the ports and the internal
// step pulse and is attached by bind.
module spline_cubic_shift_chk
    import spline_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                load_i,
    input logic [LEN_W-1:0]    len_i,
    input logic [LINE_W-1:0]   words_i,
    input logic                hold_i,
    input logic                step,
    input logic [SAMPLE_W-1:0] sample_o
);
    // Output is zero on the first edge out of reset.
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sample_o == '0);

    // A load presents word 0, or zero for an empty line.
    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> sample_o == (($past(len_i) == '0) ? '0 : $past(words_i[WORD_W-1:0])));

    // Without a step pulse or a load the output does not move.
    assert_no_step_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_i) |=> $stable(sample_o));

    // A held edge leaves the output unchanged.
    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> $stable(sample_o));
endmodule

bind spline_cubic_shift spline_cubic_shift_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .len_i    (len_i),
    .words_i  (words_i),
    .hold_i   (hold_i),
    .step     (step),
    .sample_o (sample_o)
);

// File: tb/sim_spline_cubic_shift.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each cycle from the requirements and
// queues the expected sample, and the monitor compares after each edge.
module sim_spline_cubic_shift;
    import spline_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                load_i;
    logic [LEN_W-1:0]    len_i;
    logic [LINE_W-1:0]   words_i;
    logic [3:0]          shift_i;
    logic                hold_i;
    logic [SAMPLE_W-1:0] sample_o;

    spline_cubic_shift u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .len_i(len_i),
        .words_i(words_i), .shift_i(shift_i), .hold_i(hold_i), .sample_o(sample_o)
    );

    always #2 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    logic [15:0] wbuf [N_WORDS];
    logic [31:0] m0, m1;
    logic [47:0] m2, m3;
    int          mcnt, mshift;

    // Monitor: compare each queued expectation just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #0.5;
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (sample_o !== e) begin
                    fails++;
                    $display("FAIL %s: sample_o=%h expected=%h", t, sample_o, e);
                end
            end
        end
    end

    // Drive one cycle, step the requirement model and queue its result.
    task automatic cyc(input bit ld, input int len, input int sh, input bit hd, input string tag);
        logic [15:0] p [N_WORDS];
        for (int i = 0; i < N_WORDS; i++) begin
            words_i[i*16 +: 16] = wbuf[i];
            p[i] = (i < len) ? wbuf[i] : 16'h0;
        end
        load_i  = ld;
        len_i   = LEN_W'(len);
        shift_i = 4'(sh);
        hold_i  = hd;
        if (ld) begin
            m0 = {p[0], 16'h0};
            m1 = {p[2], p[1]};
            m2 = {p[5], p[4], p[3]};
            m3 = {p[8], p[7], p[6]};
            mcnt = 0;
            mshift = sh;
        end else if (!hd) begin
            if (mcnt == (1 << mshift) - 1) begin
                m0 = m0 + m1;
                m1 = m1 + m2[47:16];
                m2 = m2 + m3;
                mcnt = 0;
            end else begin
                mcnt++;
            end
        end
        exp_q.push_back(m0[31:16]);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n, input int sh, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b0, 0, sh, 1'b0, tag);
    endtask

    task automatic setw(input logic [15:0] a0, input logic [31:0] a1,
                        input logic [47:0] a2, input logic [47:0] a3);
        wbuf[0] = a0;
        {wbuf[2], wbuf[1]} = a1;
        {wbuf[5], wbuf[4], wbuf[3]} = a2;
        {wbuf[8], wbuf[7], wbuf[6]} = a3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load_i = 1'b0; len_i = '0; words_i = '0; shift_i = '0; hold_i = 1'b0;
        m0 = '0; m1 = '0; m2 = '0; m3 = '0; mcnt = 0; mshift = 0;
        for (int i = 0; i < N_WORDS; i++) wbuf[i] = 16'h0;
        repeat (4) @(posedge clk);
        #1;
        total++;
        if (sample_o !== 16'h0) begin
            fails++;
            $display("FAIL R1: sample_o=%h expected=0000 in reset", sample_o);
        end
        rst_n = 1'b1;
        run(4, 0, "R1");

        // R3/R5: full cubic at full rate
        setw(16'h1000, 32'h0002_0000, 48'h0000_8000_0000, 48'h0000_0001_0000);
        cyc(1'b1, 9, 0, 1'b0, "R2");
        run(20, 0, "R5");
        setw(16'hF000, 32'hFFFF_4000, 48'h0003_1234_5678, 48'hFFFF_FFF0_0000);
        cyc(1'b1, 9, 0, 1'b0, "R3");
        run(12, 0, "R3");

        // R8: wrap across positive full scale
        setw(16'h7FFF, 32'h0001_0000, 48'h0, 48'h0);
        cyc(1'b1, 9, 0, 1'b0, "R8");
        run(3, 0, "R8");

        // R4: short lines are zero-padded
        for (int i = 0; i < N_WORDS; i++) wbuf[i] = 16'h1357 + 16'(i);
        cyc(1'b1, 3, 0, 1'b0, "R4");
        run(6, 0, "R4");
        cyc(1'b1, 5, 0, 1'b0, "R4");
        run(6, 0, "R4");
        cyc(1'b1, 0, 0, 1'b0, "R4");
        run(3, 0, "R4");

        // R6/R10: slow rate, shift_i changed between loads
        setw(16'h0100, 32'h0003_0000, 48'h0000_4000_0000, 48'h0);
        cyc(1'b1, 9, 2, 1'b0, "R6");
        run(9, 2, "R6");
        run(12, 0, "R10");
        cyc(1'b1, 9, 1, 1'b0, "R6");
        run(7, 5, "R10");

        // R7: hold pattern at shift 1
        cyc(1'b1, 9, 1, 1'b0, "R7");
        cyc(1'b0, 0, 1, 1'b1, "R7");
        cyc(1'b0, 0, 1, 1'b1, "R7");
        cyc(1'b0, 0, 1, 1'b0, "R7");
        cyc(1'b0, 0, 1, 1'b1, "R7");
        cyc(1'b0, 0, 1, 1'b0, "R7");
        cyc(1'b0, 0, 1, 1'b0, "R7");
        cyc(1'b0, 0, 1, 1'b1, "R7");
        run(5, 1, "R7");

        // R9: reload mid-interval while held
        cyc(1'b1, 9, 3, 1'b0, "R9");
        run(5, 3, "R9");
        setw(16'hC000, 32'hFFFE_0000, 48'h0001_0000_0000, 48'h0000_2000_0000);
        cyc(1'b1, 9, 0, 1'b1, "R9");
        cyc(1'b0, 0, 0, 1'b1, "R9");
        cyc(1'b0, 0, 0, 1'b1, "R9");
        run(10, 0, "R9");

        @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule